// File: doc/BRIEF.md
# Binary Convolution Layer Engine

This block evaluates one layer of a binarized convolutional network. Its input is a multi-channel bit-plane feature map and a set of single-bit 3x3 filter weights, both presented as flat vectors. A bit of 1 stands for +1 and a bit of 0 for -1. Each filter tap is therefore a one-bit product: the tap scores when the input bit equals the weight bit, which is XNOR. The scores over the whole window, across every input channel, are counted. A count above a fixed per-filter threshold gives an activation of 1. This replaces multiply, normalisation and sign.

The layer then applies 2x2 max-pooling. On single bits this is the OR of the four activations. Each output dimension is half the input dimension. A single start pulse launches a sequential scan that writes one pooled bit per clock, filter by filter, then row, then column. When the last bit has been written, done goes high and the whole output map is valid. The defaults form a 14x14 map of 8 channels feeding 4 filters, which gives 7x7x4 = 196 output bits. A 28x28 single-channel map feeding 8 filters is obtained by changing the parameters.

Top module: `bcl_layer_engine`

## Requirements
- R1: Flat layouts. Input bit for channel ch, row y, column x is `in_map[ch*H*W + y*W + x]`. Weight bit for filter f, channel ch, kernel row ky, kernel column kx is `weights[f*C*9 + ch*9 + ky*3 + kx]`. Pooled output bit for filter f, row r, column c is `out_map[f*(H/2)*(W/2) + r*(W/2) + c]`.
- R2: The window centred on (y, x) uses input taps (y+ky-1, x+kx-1) for every channel. A tap counts as a match when its input bit equals its weight bit.
- R3: A tap that falls outside the input border never counts as a match, whatever its weight bit.
- R4: An activation is 1 exactly when the match count is strictly greater than the filter's threshold. The threshold is field f of `THRESH`, 8 bits wide, with filter 0 in bits [7:0]. The defaults are 36, 40, 30 and 44 for filters 0 to 3.
- R5: Pooled bit (f, r, c) is the OR of the activations at positions (2r+dy, 2c+dx) for dy and dx in {0, 1}.
- R6: Output bits are written one per clock in index order. Bit i is written on the (i+1)-th rising edge after the edge that accepts start. No other bit changes on that edge.
- R7: done goes high on the edge that writes the last bit, which is edge H/2*W/2*N_FILT after the accepting edge. It stays high until the next start is accepted, and it clears on that accepting edge.
- R8: While rst_n is low at a clock edge, done is cleared, out_map is cleared to all zeros and the engine goes idle.
- R9: A start pulse while a scan is in progress is ignored. The scan continues unchanged.
- R10: While idle, out_map holds its value, even if in_map or weights change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launches a scan when idle |
| in_map | input | C*H*W | Flattened binary input feature map |
| weights | input | N_FILT*C*9 | Flattened binary filter weights |
| out_map | output | N_FILT*(H/2)*(W/2) | Flattened pooled output map |
| done | output | 1 | All output bits written |

## Verification
Output bit i is due on the (i+1)-th edge after the accepting edge, and done is due on edge H/2*W/2*N_FILT. The bench keeps a behavioural model that steps with the same edges. It compares the whole output map and done at every falling clock edge, so any bit written early, late or out of order shows up within one cycle. Explicit checks confirm that done is low one cycle before its due edge and high on it. They also confirm that a start pulse during a scan does not shift that edge, and that the map holds still across idle cycles while the inputs change.

// File: rtl/bcl_pkg.sv
package bcl_pkg;
    localparam int KSIDE = 3;
    localparam int KTAPS = KSIDE * KSIDE;
    localparam int THR_W = 8;
    localparam int POS_W = 16;

    function automatic int safe_clog2(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/bcl_window_pop.sv
module bcl_window_pop
    import bcl_pkg::*;
#(
    parameter int H     = 14,
    parameter int W     = 14,
    parameter int C     = 8,
    parameter int CNT_W = 7
) (
    input  logic [C*H*W-1:0]     in_map,
    input  logic [C*KTAPS-1:0]   wts,
    input  logic [POS_W-1:0]     cy,
    input  logic [POS_W-1:0]     cx,
    output logic [CNT_W-1:0]     cnt
);
    localparam int PLANE = H * W;

    always_comb begin
        int acc;
        acc = 0;
        for (int ch = 0; ch < C; ch++) begin
            for (int ky = 0; ky < KSIDE; ky++) begin
                for (int kx = 0; kx < KSIDE; kx++) begin
                    int iy;
                    int ix;
                    iy = int'(cy) + ky - 1;
                    ix = int'(cx) + kx - 1;
                    // padding taps never score
                    if (iy >= 0 && iy < H && ix >= 0 && ix < W) begin
                        if (in_map[ch*PLANE + iy*W + ix] == wts[ch*KTAPS + ky*KSIDE + kx])
                            acc = acc + 1;
                    end
                end
            end
        end
        cnt = CNT_W'(acc);
    end
endmodule

// File: rtl/bcl_pool_unit.sv
module bcl_pool_unit
    import bcl_pkg::*;
#(
    parameter int H = 14,
    parameter int W = 14,
    parameter int C = 8
) (
    input  logic [C*H*W-1:0]    in_map,
    input  logic [C*KTAPS-1:0]  wts,
    input  logic [THR_W-1:0]    thr,
    input  logic [POS_W-1:0]    prow,
    input  logic [POS_W-1:0]    pcol,
    output logic                pooled
);
    localparam int CNT_W = safe_clog2(C*KTAPS + 1);

    logic [3:0] act;

    for (genvar q = 0; q < 4; q++) begin : g_quad
        logic [CNT_W-1:0] cnt;
        logic [POS_W-1:0] cy;
        logic [POS_W-1:0] cx;

        assign cy = POS_W'({prow, 1'b0}) + POS_W'(q / 2);
        assign cx = POS_W'({pcol, 1'b0}) + POS_W'(q % 2);

        bcl_window_pop #(.H(H), .W(W), .C(C), .CNT_W(CNT_W)) u_pop (
            .in_map (in_map),
            .wts    (wts),
            .cy     (cy),
            .cx     (cx),
            .cnt    (cnt)
        );

        assign act[q] = (32'(cnt) > 32'(thr));
    end

    assign pooled = |act;
endmodule

// File: rtl/bcl_scan_ctrl.sv
module bcl_scan_ctrl
    import bcl_pkg::*;
#(
    parameter int HO     = 7,
    parameter int WO     = 7,
    parameter int N_FILT = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      start,
    output logic                                      busy,
    output logic                                      done,
    output logic [safe_clog2(N_FILT)-1:0]             fsel,
    output logic [POS_W-1:0]                          prow,
    output logic [POS_W-1:0]                          pcol,
    output logic [safe_clog2(N_FILT*HO*WO)-1:0]       widx
);
    localparam int TOTAL = N_FILT * HO * WO;
    localparam int FW    = safe_clog2(N_FILT);
    localparam int IW    = safe_clog2(TOTAL);
    localparam logic [IW-1:0] LAST_IDX = IW'(TOTAL - 1);

    typedef struct packed {
        logic           busy;
        logic           done;
        logic [FW-1:0]  f;
        logic [POS_W-1:0] r;
        logic [POS_W-1:0] c;
        logic [IW-1:0]  idx;
    } scan_t;

    scan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.f    = '0;
                st_d.r    = '0;
                st_d.c    = '0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + IW'(1);
                if (int'(st_q.c) == WO - 1) begin
                    st_d.c = '0;
                    if (int'(st_q.r) == HO - 1) begin
                        st_d.r = '0;
                        st_d.f = st_q.f + FW'(1);
                    end else begin
                        st_d.r = st_q.r + POS_W'(1);
                    end
                end else begin
                    st_d.c = st_q.c + POS_W'(1);
                end
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
            st_d.f    = '0;
            st_d.r    = '0;
            st_d.c    = '0;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
    assign fsel = st_q.f;
    assign prow = st_q.r;
    assign pcol = st_q.c;
    assign widx = st_q.idx;

    AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.busy); // R7
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.idx != LAST_IDX) |=> (st_q.busy && st_q.idx == $past(st_q.idx) + IW'(1))); // R9
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.idx == LAST_IDX) |=> (st_q.done && !st_q.busy)); // R7
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (int'(st_q.idx) < TOTAL)); // R6
endmodule

// File: rtl/bcl_layer_engine.sv
module bcl_layer_engine
    import bcl_pkg::*;
#(
    parameter int H      = 14,
    parameter int W      = 14,
    parameter int C      = 8,
    parameter int N_FILT = 4,
    parameter logic [N_FILT*THR_W-1:0] THRESH = {8'd44, 8'd30, 8'd40, 8'd36}
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic [C*H*W-1:0]                       in_map,
    input  logic [N_FILT*C*KTAPS-1:0]              weights,
    output logic [N_FILT*(H/2)*(W/2)-1:0]          out_map,
    output logic                                   done
);
    localparam int HO    = H / 2;
    localparam int WO    = W / 2;
    localparam int TOTAL = N_FILT * HO * WO;
    localparam int KW    = C * KTAPS;
    localparam int FW    = safe_clog2(N_FILT);
    localparam int IW    = safe_clog2(TOTAL);

    logic              busy;
    logic [FW-1:0]     fsel;
    logic [POS_W-1:0]  prow;
    logic [POS_W-1:0]  pcol;
    logic [IW-1:0]     widx;
    logic [KW-1:0]     w_f;
    logic [THR_W-1:0]  thr_f;
    logic              pooled;

    logic [TOTAL-1:0]  out_map_d, out_map_q;

    bcl_scan_ctrl #(.HO(HO), .WO(WO), .N_FILT(N_FILT)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .fsel  (fsel),
        .prow  (prow),
        .pcol  (pcol),
        .widx  (widx)
    );

    assign w_f   = weights[int'(fsel)*KW +: KW];
    assign thr_f = THRESH[int'(fsel)*THR_W +: THR_W];

    bcl_pool_unit #(.H(H), .W(W), .C(C)) u_pool (
        .in_map (in_map),
        .wts    (w_f),
        .thr    (thr_f),
        .prow   (prow),
        .pcol   (pcol),
        .pooled (pooled)
    );

    always_comb begin
        out_map_d = out_map_q;
        if (busy) out_map_d[widx] = pooled;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_map_q <= '0;
        else        out_map_q <= out_map_d;
    end

    assign out_map = out_map_q;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(out_map_q)); // R10
    AST_ONE_BIT_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones(out_map_q ^ $past(out_map_q)) <= 1)); // R6
endmodule

// File: tb/bcl_layer_engine_tb.sv
module bcl_layer_engine_tb;
    localparam int H = 14, W = 14, C = 8, NF = 4;
    localparam int HO = H / 2, WO = W / 2;
    localparam int TOTAL = NF * HO * WO;
    localparam int NIN = C * H * W;
    localparam int NW = NF * C * 9;
    localparam int THR [NF] = '{36, 40, 30, 44};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NIN-1:0] in_v = '0;
    logic [NW-1:0] w_v = '0;
    logic [TOTAL-1:0] out_map;
    logic done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit comparing = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    bcl_layer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_map(in_v), .weights(w_v),
        .out_map(out_map), .done(done)
    );

    function automatic bit ref_bit(int i);
        int f = i / (HO * WO);
        int r = (i % (HO * WO)) / WO;
        int c = i % WO;
        bit res = 1'b0;
        for (int q = 0; q < 4; q++) begin
            int y = 2 * r + q / 2;
            int x = 2 * c + q % 2;
            int cnt = 0;
            for (int ch = 0; ch < C; ch++)
                for (int ky = -1; ky <= 1; ky++)
                    for (int kx = -1; kx <= 1; kx++) begin
                        int iy = y + ky;
                        int ix = x + kx;
                        if (iy >= 0 && iy < H && ix >= 0 && ix < W)
                            if (in_v[ch*H*W + iy*W + ix] == w_v[f*C*9 + ch*9 + (ky+1)*3 + (kx+1)])
                                cnt++;
                    end
            if (cnt > THR[f]) res = 1'b1;
        end
        return res;
    endfunction

    // behavioural model stepping with the DUT edges
    bit m_busy = 0, m_done = 0;
    int m_idx = 0;
    logic [TOTAL-1:0] m_out = '0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_idx = 0; m_out = '0;
        end else if (m_busy) begin
            m_out[m_idx] = ref_bit(m_idx);
            if (m_idx == TOTAL - 1) begin m_busy = 0; m_done = 1; m_idx = 0; end
            else m_idx++;
        end else if (start) begin
            m_busy = 1; m_done = 0; m_idx = 0;
        end
    end

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (comparing && rst_n) begin
            int bad = -1;
            for (int i = 0; i < TOTAL; i++) if (bad < 0 && out_map[i] !== m_out[i]) bad = i;
            check(bad < 0, cur_req, $sformatf("out_map bit %0d", bad < 0 ? 0 : bad),
                  bad < 0 ? 64'd0 : 64'(out_map[bad]), bad < 0 ? 64'd0 : 64'(m_out[bad]));
            check(done === m_done, "R7", "done", 64'(done), 64'(m_done));
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic fill_random();
        for (int i = 0; i < NIN; i++) in_v[i] = 1'($urandom);
        for (int i = 0; i < NW; i++) w_v[i] = 1'($urandom);
    endtask

    // pulse start and walk to the due edge of done; optional stray start mid-scan
    task automatic run_layer(int stray_at);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;     // after accepting edge E0
        for (int k = 1; k <= TOTAL; k++) begin
            if (k == stray_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (k == TOTAL - 1) check(done == 1'b0, "R7", "done before due edge", 64'(done), 64'd0);
            if (k == TOTAL)     check(done == 1'b1, "R7", "done on due edge", 64'(done), 64'd1);
        end
        if (stray_at > 0) check(done == 1'b1, "R9", "scan unaffected by stray start", 64'(done), 64'd1);
    endtask

    initial begin
        logic [TOTAL-1:0] snap;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R8", "done in reset", 64'(done), 64'd0);
        check(out_map == '0, "R8", "out_map in reset", 64'(out_map[63:0]), 64'd0);
        rst_n = 1'b1;
        comparing = 1'b1;
        @(negedge clk);

        cur_req = "R2,R3,R4,R5,R1";
        fill_random();
        run_layer(0);

        cur_req = "R3 all-ones";
        in_v = '1; w_v = '1;
        run_layer(0);

        cur_req = "R2 zero map";
        in_v = '0;
        for (int i = 0; i < NW; i++) w_v[i] = 1'($urandom);
        run_layer(0);

        cur_req = "R9 stray start";
        fill_random();
        run_layer(TOTAL / 2);

        cur_req = "R10 idle hold";
        snap = out_map;
        for (int k = 0; k < 5; k++) begin
            fill_random();
            @(negedge clk);
            check(out_map == snap, "R10", "out_map held while idle", 64'(out_map[63:0]), 64'(snap[63:0]));
        end

        cur_req = "R4 checkerboard";
        for (int i = 0; i < NIN; i++) in_v[i] = 1'(((i % W) + (i / W)) % 2);
        for (int i = 0; i < NW; i++) w_v[i] = 1'(i % 2);
        run_layer(0);

        cur_req = "R6 restart";
        fill_random();
        run_layer(3);

        comparing = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(done == 1'b0, "R8", "done after reset", 64'(done), 64'd0);
        check(out_map == '0, "R8", "out_map after reset", 64'(out_map[63:0]), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule